// File: doc/BRIEF.md
# Gate-Enable Waveform Generator

The block drives the output-enable lines of a display gate driver. Three enable outputs are each produced by playing out a 48-bit bitmap held in its own pattern register, one bit per sub-tick, and the same timebase generates the line clock. One line-clock period spans 16 sub-ticks, so one pass through a bitmap covers three line-clock periods. After that pass the bitmap repeats.

A programmable prescaler sets the sub-tick length in system clocks. Software changes a waveform by writing a new bitmap. The new bitmap is held back until the current pass completes, so a partial mix of two bitmaps never reaches an output. The three outputs are staggered by one line-clock period each. Lane 0 starts with the first line-clock pulse of the three-pulse cycle, lane 1 with the second and lane 2 with the third. This staggering lets fine gate-bias or blanking adjustments be made through the bitmaps alone.

Top module: `gate_oe_gen`

## Requirements
- R1: Each of the three outputs `gate_oe_o[k]` has its own 48-bit bitmap, written through `wr_data_i` when `wr_en_i` is high and `wr_sel_i` equals k. A bitmap bit of 1 makes the output high and a bit of 0 makes it low.
- R2: A position counter runs from 0 to 47. While it holds value p, output k shows bitmap bit (p − 16·k) mod 48. Bits are therefore played out starting from bit 0 (the LSB), and lanes 1 and 2 trail lane 0 by 16 and 32 positions.
- R3: The position counter holds each value for `presc_i`+1 system clocks, then steps by one. After 47 it returns to 0.
- R4: With `presc_i` = 0 the position counter advances on every system clock and skips no bitmap bit.
- R5: `line_clk_o` is high while (position mod 16) < 8 and low otherwise when `phase_inv_i` = 0. With `phase_inv_i` = 1 it is inverted.
- R6: A bitmap written while enabled reaches its output only at the next step of the position counter from 47 to 0. While `en_i` is low, a written bitmap is taken over on the next clock.
- R7: When `en_i` is low at a clock edge, the prescaler and position counters are cleared at that edge. From the edge on, `line_clk_o` and all of `gate_oe_o` are low, whatever the value of `phase_inv_i`.
- R8: While `rst_ni` is low, all outputs are low, and both counters and all bitmaps are zero.
- R9: A write with `wr_sel_i` = 3 changes no bitmap.
- R10: All outputs are registered. The output value seen after a clock edge reflects the position, bitmap, enable and phase that were present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the timebase and silences all outputs |
| presc_i | input | 8 | Sub-tick length minus one, in system clocks |
| phase_inv_i | input | 1 | Inverts the line-clock polarity |
| wr_en_i | input | 1 | Bitmap write strobe |
| wr_sel_i | input | 2 | Target lane of the write (0 to 2) |
| wr_data_i | input | 48 | Bitmap value to write |
| line_clk_o | output | 1 | Line clock |
| gate_oe_o | output | 3 | Gate output-enable waveforms, one bit per lane |

## Verification
Every output is due one system clock after the edge that samples the position, enable and phase. A bitmap write becomes visible one clock after the first 47-to-0 step that follows it, or one clock after a disabled write edge. The bench keeps a reference position counter, prescale counter and a pending and active copy of each bitmap. At each rising edge it computes the value due for the following cycle from the state before that edge and queues it. A monitor compares each queued item at the next falling edge, so each output is checked exactly in the cycle it is due.

// File: rtl/gate_oe_pkg.sv
package gate_oe_pkg;
  // lane k reads bitmap at (pos - k*sub) mod pat_w; expressed as an add-offset
  function automatic int unsigned lane_offset(int unsigned lane, int unsigned sub,
                                              int unsigned pat_w);
    return (pat_w - ((lane * sub) % pat_w)) % pat_w;
  endfunction
endpackage

// File: rtl/gate_oe_timebase.sv
module gate_oe_timebase #(
  parameter int unsigned PAT_W = 48,
  parameter int unsigned PRE_W = 8,
  localparam int unsigned POS_W = $clog2(PAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             wrap_o,
  output logic [POS_W-1:0] pos_o
);
  logic [PRE_W-1:0] pre_q;
  logic [POS_W-1:0] pos_q;
  logic             tick;

  assign tick   = en_i && (pre_q >= presc_i);
  assign wrap_o = tick && (pos_q == POS_W'(PAT_W - 1));
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      pos_q <= '0;
    end else if (!en_i) begin
      pre_q <= '0;
      pos_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      pos_q <= wrap_o ? '0 : pos_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  p_pos_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < POS_W'(PAT_W));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick) |=> $stable(pos_q));
  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (pos_q == '0));
  p_fast_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && presc_i == '0) |=> (pos_q != $past(pos_q)));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pos_q == '0 && pre_q == '0));
endmodule

// File: rtl/gate_oe_lane.sv
module gate_oe_lane #(
  parameter int unsigned PAT_W = 48,
  parameter int unsigned SUB   = 16,
  parameter int unsigned LANE  = 0,
  localparam int unsigned POS_W = $clog2(PAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wrap_i,
  input  logic             wr_i,
  input  logic [PAT_W-1:0] wr_data_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             oe_o
);
  localparam int unsigned OFS = gate_oe_pkg::lane_offset(LANE, SUB, PAT_W);

  logic [PAT_W-1:0] shadow_q, active_q;
  logic [POS_W:0]   sum;
  logic [POS_W-1:0] idx;
  logic             oe_q;

  assign sum  = {1'b0, pos_i} + (POS_W+1)'(OFS);
  assign idx  = (sum >= (POS_W+1)'(PAT_W)) ? POS_W'(sum - (POS_W+1)'(PAT_W)) : sum[POS_W-1:0];
  assign oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (wr_i) shadow_q <= wr_data_i;
      // swap only at pattern boundary so no pass mixes two bitmaps
      if (wrap_i || !en_i) active_q <= shadow_q;
      oe_q <= en_i && active_q[idx];
    end
  end

  p_swap_at_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_i) |=> $stable(active_q));
  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx < POS_W'(PAT_W));
endmodule

// File: rtl/gate_oe_gen.sv
module gate_oe_gen #(
  parameter int unsigned PAT_W   = 48,
  parameter int unsigned SUB     = 16,
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned PRE_W   = 8,
  localparam int unsigned POS_W  = $clog2(PAT_W),
  localparam int unsigned SUB_W  = $clog2(SUB),
  localparam int unsigned SEL_W  = $clog2(NUM_OUT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRE_W-1:0]   presc_i,
  input  logic               phase_inv_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [PAT_W-1:0]   wr_data_i,
  output logic               line_clk_o,
  output logic [NUM_OUT-1:0] gate_oe_o
);
  logic             wrap;
  logic [POS_W-1:0] pos;
  logic             line_q;

  gate_oe_timebase #(.PAT_W(PAT_W), .PRE_W(PRE_W)) i_timebase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .presc_i (presc_i),
    .wrap_o  (wrap),
    .pos_o   (pos)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    gate_oe_lane #(.PAT_W(PAT_W), .SUB(SUB), .LANE(g)) i_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .wrap_i    (wrap),
      .wr_i      (wr_en_i && (wr_sel_i == SEL_W'(g))),
      .wr_data_i (wr_data_i),
      .pos_i     (pos),
      .oe_o      (gate_oe_o[g])
    );
  end

  // high for the first half of each line period in default phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= en_i && (!pos[SUB_W-1] ^ phase_inv_i);
  end
  assign line_clk_o = line_q;

  p_off_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_oe_o == '0 && !line_clk_o));
  p_line_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !phase_inv_i && pos == '0) |=> line_clk_o);
endmodule

// File: tb/test_gate_oe_gen.sv
module test_gate_oe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 48;
  localparam int SB = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  presc_i = '0;
  logic        phase_inv_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [47:0] wr_data_i = '0;
  logic        line_clk_o;
  logic [2:0]  gate_oe_o;

  gate_oe_gen i_gate_oe_gen (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .presc_i(presc_i),
    .phase_inv_i(phase_inv_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .line_clk_o(line_clk_o), .gate_oe_o(gate_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_pos = 0, m_cnt = 0;
  logic [47:0] m_shadow [3];
  logic [47:0] m_active [3];
  int total = 0, bad = 0;
  bit done = 0;

  bit         q_line [$];
  logic [2:0] q_oe [$];
  string      q_tag [$];

  task automatic step(string tag);
    bit exp_line;
    logic [2:0] exp_oe;
    logic [47:0] old_sh [3];
    bit wrap;
    exp_line = en_i && (((m_pos % SB) < SB/2) ^ phase_inv_i);
    for (int k = 0; k < 3; k++) exp_oe[k] = en_i && m_active[k][(m_pos + PW - SB*k) % PW];
    @(posedge clk);
    old_sh = m_shadow;
    wrap = en_i && (m_cnt >= int'(presc_i)) && (m_pos == PW-1);
    for (int k = 0; k < 3; k++) if (!en_i || wrap) m_active[k] = old_sh[k];
    if (wr_en_i && wr_sel_i < 2'd3) m_shadow[wr_sel_i] = wr_data_i;
    if (!en_i) begin m_cnt = 0; m_pos = 0; end
    else if (m_cnt >= int'(presc_i)) begin m_cnt = 0; m_pos = (m_pos == PW-1) ? 0 : m_pos + 1; end
    else m_cnt++;
    q_line.push_back(exp_line);
    q_oe.push_back(exp_oe);
    q_tag.push_back(tag);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [47:0] d, input string tag);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step(tag);
    wr_en_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (q_oe.size() > 0) begin
      bit el; logic [2:0] eo; string t;
      el = q_line.pop_front(); eo = q_oe.pop_front(); t = q_tag.pop_front();
      total++;
      if (line_clk_o !== el || gate_oe_o !== eo) begin
        bad++;
        $display("FAIL %s: line=%0b oe=%b expected line=%0b oe=%b", t, line_clk_o, gate_oe_o, el, eo);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R3: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin m_shadow[k] = '0; m_active[k] = '0; end
    // R8: outputs low in reset even with enable and inverted phase
    en_i = 1'b1; phase_inv_i = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      total++;
      if (line_clk_o !== 1'b0 || gate_oe_o !== 3'b000) begin
        bad++;
        $display("FAIL R8: line=%0b oe=%b expected line=0 oe=000", line_clk_o, gate_oe_o);
      end
    end
    @(posedge clk); #1;
    en_i = 1'b0; rst_ni = 1'b1;

    // R7/R1/R9: load bitmaps while disabled, outputs stay low
    wr(2'd0, 48'hC003_8001_F00F, "R1");
    wr(2'd1, 48'h0F0F_3C3C_A5A5, "R1");
    wr(2'd2, 48'h1234_5678_9ABC, "R1");
    wr(2'd3, 48'hFFFF_FFFF_FFFF, "R9");
    repeat (4) step("R7");

    phase_inv_i = 1'b0; presc_i = 8'd2; en_i = 1'b1;
    repeat (2*PW*3) step("R1 R2 R3");
    en_i = 1'b0;
    repeat (3) step("R7");
    presc_i = 8'd0; en_i = 1'b1;
    repeat (2*PW) step("R4");
    phase_inv_i = 1'b1;
    repeat (64) step("R5");
    phase_inv_i = 1'b0;
    en_i = 1'b0; step("R7");
    presc_i = 8'd1; en_i = 1'b1;
    repeat (20) step("R10");
    wr(2'd0, 48'hFFFF_0000_5555, "R6");
    repeat (2*PW*2 + 10) step("R6");
    wr(2'd3, 48'hFFFF_FFFF_FFFF, "R9");
    repeat (PW*2 + 10) step("R9");
    wr(2'd2, 48'h0000_0000_0001, "R6");
    repeat (30) step("R6");
    phase_inv_i = 1'b1; en_i = 1'b0;
    repeat (5) step("R7");

    @(posedge clk); @(posedge clk);
    wait (q_oe.size() == 0);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule